// File: doc/BRIEF.md
# Stub Frame Serializer

The block takes the stubs found in one bunch crossing (at most three, each an 8-bit half-strip cluster address on the bottom layer and a 5-bit bend that locates the matching cluster inside the top-layer window), together with one bit of triggered readout data. It builds a fixed 40-bit frame from them and spreads that frame over 10 serial lines. Each line carries 4 bits per crossing. The block runs on a clock four times the crossing rate, and a one-cycle crossing strobe marks the start of each crossing.

Before packing, the valid stubs are put in ascending address order. Stub slots that no valid stub fills are sent as zeros. The frame is captured into a register when a strobe is accepted, and the four slot cycles then send that captured copy. One crossing's serial output therefore never carries bits from the next crossing's inputs.

Control is a five-state machine:
- Idle: nothing is being sent.
- Slot0, Slot1, Slot2, Slot3: the four serial slots.

Its transitions are:
- Idle goes to Slot0 on a strobe. Without a strobe it stays in Idle.
- Slot0 goes to Slot1, Slot1 goes to Slot2 and Slot2 goes to Slot3 unconditionally. A strobe in any of these three states is ignored.
- Slot3 goes to Slot0 on a strobe, which gives back-to-back frames. Without a strobe it returns to Idle.

Top module: `stub_frame_ser`

## Requirements
- R1: While reset is asserted and after it is released, the machine is in Idle and all 10 lines drive 0.
- R2: A strobe seen at a clock edge while in Idle or Slot3 captures a frame. The four following cycles are Slot0 to Slot3. In slot s, line l drives frame bit 4*l+s, where bit 0 is the first bit of the frame.
- R3: The frame layout starts with stub slot 1: its address from bit 0 to bit 7, MSB first, then its bend from bit 8 to bit 12, MSB first. Stub slot 2 takes bits 13 to 25 in the same form, and stub slot 3 takes bits 26 to 38. The readout bit is bit 39, sent on line 9 in Slot3.
- R4: Only the first N input stubs are valid, where N is the count input (0 to 3). Stub slots after the N-th hold all zeros.
- R5: The valid stubs fill the stub slots in ascending address order. When two addresses are equal, the stub with the lower input index comes first.
- R6: A strobe during Slot0, Slot1 or Slot2 is ignored. The current frame completes unchanged.
- R7: From Slot3 with no strobe, the machine returns to Idle, and all lines drive 0.
- R8: Strobes every four cycles produce back-to-back frames with no idle cycle between them.
- R9: Input changes after a frame has been captured do not alter that frame's serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock, four times the crossing rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| xing_i | input | 1 | Crossing strobe, one cycle wide |
| stub_cnt_i | input | 2 | Number of valid stubs (0 to 3) |
| stub_addr_i | input | 24 | Stub addresses, stub i at bits [8i+7:8i] |
| stub_bend_i | input | 15 | Stub bends, stub i at bits [5i+4:5i] |
| ro_bit_i | input | 1 | Triggered readout data bit |
| line_o | output | 10 | Serial output lines |

## Verification
On every cycle, the assertions check the following:
- The state follows the slot sequence after an accepted strobe, and an early strobe never restarts it.
- The captured frame stays stable through its four slots.
- The lines are quiet in Idle.
- An empty crossing sends only the readout bit, which appears on the last line in Slot3.

Only the bench scenarios can show that the stub bits land in the right positions, and they rely on a behavioural reference model to do so. These scenarios cover ascending address order with stable tie handling, zero filling for partial counts, and correct frames under back-to-back and randomly spaced strobes.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // serial slots per crossing (fixed by the slot state machine)
    localparam int SLOTS = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SLOT0 = 3'd1,
        ST_SLOT1 = 3'd2,
        ST_SLOT2 = 3'd3,
        ST_SLOT3 = 3'd4
    } slot_state_e;

endpackage

// File: rtl/sfs_stub_rank.sv
// Orders the valid stubs by ascending address (stable on ties) and zero-fills unused slots.
module sfs_stub_rank #(
    parameter int NSTUB  = 3,
    parameter int ADDR_W = 8,
    parameter int BEND_W = 5,
    localparam int CNT_W = $clog2(NSTUB + 1)
) (
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [NSTUB*ADDR_W-1:0] addr_i,
    input  logic [NSTUB*BEND_W-1:0] bend_i,
    output logic [NSTUB*ADDR_W-1:0] addr_o,
    output logic [NSTUB*BEND_W-1:0] bend_o
);

    logic [NSTUB-1:0] valid;
    logic [CNT_W-1:0] rank [NSTUB];

    always_comb begin
        for (int i = 0; i < NSTUB; i++) begin
            valid[i] = CNT_W'(i) < cnt_i;
        end
    end

    // rank = number of valid stubs that must precede this one
    always_comb begin
        for (int i = 0; i < NSTUB; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NSTUB; j++) begin
                if (j != i && valid[j]) begin
                    if ((addr_i[j*ADDR_W +: ADDR_W] < addr_i[i*ADDR_W +: ADDR_W]) ||
                        ((addr_i[j*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W]) && (j < i))) begin
                        rank[i] = rank[i] + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        addr_o = '0;
        bend_o = '0;
        for (int s = 0; s < NSTUB; s++) begin
            for (int i = 0; i < NSTUB; i++) begin
                if (valid[i] && rank[i] == CNT_W'(s)) begin
                    addr_o[s*ADDR_W +: ADDR_W] = addr_i[i*ADDR_W +: ADDR_W];
                    bend_o[s*BEND_W +: BEND_W] = bend_i[i*BEND_W +: BEND_W];
                end
            end
        end
    end

endmodule

// File: rtl/sfs_frame_pack.sv
// Places ordered stubs and the readout bit into stream order; frame bit k is the k-th bit sent.
module sfs_frame_pack #(
    parameter int NSTUB     = 3,
    parameter int ADDR_W    = 8,
    parameter int BEND_W    = 5,
    parameter int FRAME_PAD = 40,
    localparam int STUB_W   = ADDR_W + BEND_W,
    localparam int FRAME_W  = NSTUB * STUB_W + 1
) (
    input  logic [NSTUB*ADDR_W-1:0] addr_i,
    input  logic [NSTUB*BEND_W-1:0] bend_i,
    input  logic                    ro_i,
    output logic [FRAME_PAD-1:0]    frame_o
);

    for (genvar s = 0; s < NSTUB; s++) begin : g_stub
        for (genvar b = 0; b < ADDR_W; b++) begin : g_addr
            assign frame_o[s*STUB_W + b] = addr_i[s*ADDR_W + ADDR_W - 1 - b];
        end
        for (genvar b = 0; b < BEND_W; b++) begin : g_bend
            assign frame_o[s*STUB_W + ADDR_W + b] = bend_i[s*BEND_W + BEND_W - 1 - b];
        end
    end

    assign frame_o[FRAME_W-1] = ro_i;

    if (FRAME_PAD > FRAME_W) begin : g_pad
        assign frame_o[FRAME_PAD-1:FRAME_W] = '0;
    end

endmodule

// File: rtl/sfs_slot_fsm.sv
// Slot sequencer: captures a frame on an accepted strobe and walks the four serial slots.
module sfs_slot_fsm
    import sfs_pkg::*;
#(
    parameter int LANES      = 10,
    localparam int FRAME_PAD = LANES * SLOTS
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 xing_i,
    input  logic [FRAME_PAD-1:0] frame_d,
    output slot_state_e          state_q,
    output logic [FRAME_PAD-1:0] frame_q,
    output logic [LANES-1:0]     line_o
);

    slot_state_e state_d;
    logic        accept;

    function automatic logic [LANES-1:0] pick(input logic [FRAME_PAD-1:0] fr, input int slot);
        logic [LANES-1:0] v;
        for (int l = 0; l < LANES; l++) begin
            v[l] = fr[l*SLOTS + slot];
        end
        return v;
    endfunction

    always_comb begin
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xing_i) begin
                    accept  = 1'b1;
                    state_d = ST_SLOT0;
                end
            end
            ST_SLOT0: state_d = ST_SLOT1;
            ST_SLOT1: state_d = ST_SLOT2;
            ST_SLOT2: state_d = ST_SLOT3;
            ST_SLOT3: begin
                if (xing_i) begin
                    accept  = 1'b1;
                    state_d = ST_SLOT0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                frame_q <= frame_d;
            end
        end
    end

    // output process
    always_comb begin
        line_o = '0;
        unique case (state_q)
            ST_IDLE:  line_o = '0;
            ST_SLOT0: line_o = pick(frame_q, 0);
            ST_SLOT1: line_o = pick(frame_q, 1);
            ST_SLOT2: line_o = pick(frame_q, 2);
            ST_SLOT3: line_o = pick(frame_q, 3);
            default:  line_o = '0;
        endcase
    end

endmodule

// File: rtl/stub_frame_ser.sv
module stub_frame_ser
    import sfs_pkg::*;
#(
    parameter int NSTUB   = 3,
    parameter int ADDR_W  = 8,
    parameter int BEND_W  = 5,
    localparam int CNT_W     = $clog2(NSTUB + 1),
    localparam int FRAME_W   = NSTUB * (ADDR_W + BEND_W) + 1,
    localparam int LANES     = (FRAME_W + SLOTS - 1) / SLOTS,
    localparam int FRAME_PAD = LANES * SLOTS
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    xing_i,
    input  logic [CNT_W-1:0]        stub_cnt_i,
    input  logic [NSTUB*ADDR_W-1:0] stub_addr_i,
    input  logic [NSTUB*BEND_W-1:0] stub_bend_i,
    input  logic                    ro_bit_i,
    output logic [LANES-1:0]        line_o
);

    logic [NSTUB*ADDR_W-1:0] ord_addr;
    logic [NSTUB*BEND_W-1:0] ord_bend;
    logic [FRAME_PAD-1:0]    frame_d;
    logic [FRAME_PAD-1:0]    frame_q;
    slot_state_e             state_q;

    sfs_stub_rank #(.NSTUB(NSTUB), .ADDR_W(ADDR_W), .BEND_W(BEND_W)) u_rank (
        .cnt_i  (stub_cnt_i),
        .addr_i (stub_addr_i),
        .bend_i (stub_bend_i),
        .addr_o (ord_addr),
        .bend_o (ord_bend)
    );

    sfs_frame_pack #(.NSTUB(NSTUB), .ADDR_W(ADDR_W), .BEND_W(BEND_W), .FRAME_PAD(FRAME_PAD)) u_pack (
        .addr_i  (ord_addr),
        .bend_i  (ord_bend),
        .ro_i    (ro_bit_i),
        .frame_o (frame_d)
    );

    sfs_slot_fsm #(.LANES(LANES)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .xing_i  (xing_i),
        .frame_d (frame_d),
        .state_q (state_q),
        .frame_q (frame_q),
        .line_o  (line_o)
    );

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
    import sfs_pkg::*;
#(
    parameter int LANES     = 10,
    parameter int CNT_W     = 2,
    parameter int FRAME_PAD = 40
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 xing_i,
    input logic [CNT_W-1:0]     stub_cnt_i,
    input logic                 ro_bit_i,
    input logic [LANES-1:0]     line_o,
    input slot_state_e          state_q,
    input logic [FRAME_PAD-1:0] frame_q
);

    // phase 0 = idle, 1..SLOTS = serial slot number + 1
    logic [2:0]       ph;
    logic [CNT_W-1:0] cnt_s;
    logic             ro_s;
    logic             acc;

    assign acc = xing_i && (ph == 3'd0 || ph == 3'(SLOTS));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph    <= '0;
            cnt_s <= '0;
            ro_s  <= 1'b0;
        end else if (acc) begin
            ph    <= 3'd1;
            cnt_s <= stub_cnt_i;
            ro_s  <= ro_bit_i;
        end else if (ph != 3'd0 && ph != 3'(SLOTS)) begin
            ph <= ph + 3'd1;
        end else begin
            ph <= 3'd0;
        end
    end

    p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph == 3'd0) |-> (line_o == '0));

    p_slot_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph != 3'd0) |-> (3'(state_q) == ph));

    p_early_strobe_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xing_i && ph != 3'd0 && ph != 3'(SLOTS)) |=> (state_q != ST_SLOT0));

    p_frame_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph > 3'd1) |-> $stable(frame_q));

    p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph != 3'd0 && ph != 3'(SLOTS) && cnt_s == '0) |-> (line_o == '0));

    p_ro_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph == 3'(SLOTS)) |-> (line_o[LANES-1] == ro_s));

endmodule

bind stub_frame_ser sfs_checker #(.LANES(LANES), .CNT_W(CNT_W), .FRAME_PAD(FRAME_PAD)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xing_i     (xing_i),
    .stub_cnt_i (stub_cnt_i),
    .ro_bit_i   (ro_bit_i),
    .line_o     (line_o),
    .state_q    (state_q),
    .frame_q    (frame_q)
);

// File: tb/tb_stub_frame_ser.sv
`timescale 1ns/1ps
module tb_stub_frame_ser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xing = 1'b0;
    logic [1:0]  cnt = '0;
    logic [23:0] addr_v = '0;
    logic [14:0] bend_v = '0;
    logic        ro = 1'b0;
    logic [9:0]  line_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stub_frame_ser dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .xing_i      (xing),
        .stub_cnt_i  (cnt),
        .stub_addr_i (addr_v),
        .stub_bend_i (bend_v),
        .ro_bit_i    (ro),
        .line_o      (line_o)
    );

    // ---------------- behavioural reference model ----------------
    int          mph = 0;
    logic [39:0] mfr = '0;   // mfr[k] = k-th bit sent

    function automatic logic [39:0] build_frame();
        int q[$];
        logic [39:0] f = '0;
        for (int i = 0; i < int'(cnt); i++) begin
            int pos = q.size();
            while (pos > 0 && addr_v[q[pos-1]*8 +: 8] > addr_v[i*8 +: 8]) pos--;
            q.insert(pos, i);
        end
        for (int s = 0; s < q.size(); s++) begin
            logic [7:0] a = addr_v[q[s]*8 +: 8];
            logic [4:0] b = bend_v[q[s]*5 +: 5];
            for (int k = 0; k < 8; k++) f[13*s + k] = a[7-k];
            for (int k = 0; k < 5; k++) f[13*s + 8 + k] = b[4-k];
        end
        f[39] = ro;
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0;
        end else if (xing && (mph == 0 || mph == 4)) begin
            mfr = build_frame();
            mph = 1;
        end else if (mph > 0 && mph < 4) begin
            mph = mph + 1;
        end else begin
            mph = 0;
        end
    end

    function automatic logic [9:0] exp_lines();
        logic [9:0] e = '0;
        if (mph != 0) begin
            for (int l = 0; l < 10; l++) e[l] = mfr[4*l + mph - 1];
        end
        return e;
    endfunction

    // ---------------- helpers ----------------
    task automatic check_val(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: line_o actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        check_val(tag, line_o, exp_lines());
    endtask

    task automatic set_stubs(input logic [1:0] c, input logic [23:0] a, input logic [14:0] b, input logic r);
        cnt = c; addr_v = a; bend_v = b; ro = r;
    endtask

    task automatic rand_stubs();
        cnt = 2'($urandom_range(0, 3));
        addr_v = 24'($urandom);
        bend_v = 15'($urandom);
        ro = 1'($urandom);
    endtask

    // send one frame: strobe for one cycle, then three more slots
    task automatic frame(input string tag);
        xing = 1'b1;
        tick(tag);
        xing = 1'b0;
        for (int i = 0; i < 3; i++) tick(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) tick("R1 reset");
        check_val("R1 reset lines", line_o, 10'h000);
        rst_n = 1'b1;
        tick("R1 after reset");
        tick("R1 idle");

        // R2 R3 R5: three unsorted stubs
        set_stubs(2'd3, {8'h5A, 8'h15, 8'h9C}, {5'h11, 5'h0A, 5'h1F}, 1'b1);
        frame("R2 R3 R5 full frame");
        tick("R7 return to idle");
        tick("R7 idle quiet");

        // R3 directed: empty crossing, readout bit only on line 9 slot 3
        set_stubs(2'd0, 24'hFFFFFF, 15'h7FFF, 1'b1);
        xing = 1'b1; tick("R4 empty slot0"); xing = 1'b0;
        check_val("R4 empty slot0 literal", line_o, 10'h000);
        tick("R4 empty slot1");
        tick("R4 empty slot2");
        tick("R3 readout slot3");
        check_val("R3 readout bit on line 9", line_o, 10'h200);
        tick("R7 idle");

        // R3 directed: single stub addr 0x80 bend 0 -> only frame bit 0 (line 0 slot 0)
        set_stubs(2'd1, {8'h00, 8'h00, 8'h80}, 15'h0, 1'b0);
        xing = 1'b1; tick("R3 single stub slot0"); xing = 1'b0;
        check_val("R3 address MSB first", line_o, 10'h001);
        for (int i = 0; i < 3; i++) tick("R3 single stub");

        // R4: partial counts with junk in unused entries
        set_stubs(2'd1, {8'h01, 8'h02, 8'hC3}, {5'h1F, 5'h1F, 5'h05}, 1'b0);
        frame("R4 one stub");
        set_stubs(2'd2, {8'h00, 8'hE0, 8'h70}, {5'h1F, 5'h03, 5'h1C}, 1'b1);
        frame("R4 R5 two stubs");

        // R5: ties keep input order
        set_stubs(2'd3, {8'h33, 8'h33, 8'h33}, {5'h03, 5'h02, 5'h01}, 1'b0);
        frame("R5 equal addresses");
        set_stubs(2'd3, {8'h40, 8'h10, 8'h40}, {5'h07, 5'h18, 5'h01}, 1'b1);
        frame("R5 partial tie");
        tick("R7 idle");

        // R6: strobe during slots 0..2 ignored
        set_stubs(2'd2, {8'h00, 8'h22, 8'h11}, {5'h00, 5'h0F, 5'h10}, 1'b1);
        xing = 1'b1; tick("R6 accept");
        set_stubs(2'd3, 24'hABCDEF, 15'h5555, 1'b0);
        tick("R6 strobe in slot1 ignored");
        tick("R6 strobe in slot2 ignored");
        xing = 1'b0;
        tick("R6 frame unchanged slot3");
        tick("R7 idle after");

        // R9: inputs change every cycle after capture
        set_stubs(2'd3, {8'hF0, 8'h0F, 8'h88}, {5'h15, 5'h0A, 5'h1B}, 1'b0);
        xing = 1'b1; tick("R9 capture"); xing = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rand_stubs();
            tick("R9 inputs changed");
        end
        tick("R7 idle");

        // R8: back-to-back frames
        for (int f = 0; f < 12; f++) begin
            rand_stubs();
            frame("R8 back-to-back");
        end
        xing = 1'b0;
        tick("R7 idle after burst");

        // R2: random strobe spacing soak
        for (int i = 0; i < 600; i++) begin
            rand_stubs();
            xing = ($urandom_range(0, 3) == 0);
            tick("R2 random soak");
        end
        xing = 1'b0;
        tick("R2 soak end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule